// File: doc/BRIEF.md
# Power-Stage Overcurrent Timeout and Fault Supervisor

This block watches a powered output port once a start-up sequencer has switched it on. It measures how long the analog current regulator reports that it is holding the load at its limit. It counts in whole milliseconds, and the count starts again from zero each time the load falls back below the limit. A load that stays at the limit for the full timeout turns the switch off and pulls the active-low fault flag down. An over-temperature report has the same effect. The hot condition is remembered until a separate "cooled" flag arrives, and this gap between the trip and release points is the thermal hysteresis.

Recovery follows one of two policies, chosen by a mode input. In latch-off mode the switch stays off until enable is dropped and raised again. In auto-retry mode recovery begins on its own. Both policies end with the same fixed restart delay, which starts only once the port is no longer hot. When the delay ends, the block sends a one-cycle restart request back to the sequencer. A qualifier sent with the request tells the sequencer whether to restart at discovery or go straight to power-up, depending on whether discovery is disabled. The fault flag stays low until the sequencer signals the start of the next powered phase.

Top module: `ocf_supervisor`

## Requirements
- R1: While powered with `ilim_active` high, a millisecond counter advances once every CLK_PER_MS clocks. After OC_LIMIT_MS x CLK_PER_MS consecutive sampled cycles of current limit, the registered outputs show `sw_off`=1 and `fault_n`=0.
- R2: A single sampled cycle with `ilim_active` low clears the elapsed limit time, so the next overload needs the full OC_LIMIT_MS again.
- R3: After a fault, `sw_off` stays 1 and `fault_n` stays 0 for as long as the block waits to recover.
- R4: When `ot_trip` is sampled high, the block records a hot condition. On the next edge a powered port is switched off and `fault_n` goes to 0. The hot condition stays set until `ot_clear` is sampled high, and `ot_trip` wins if both are high in the same cycle.
- R5: With `latch_mode`=1 a fault keeps the switch off indefinitely. Lowering `enable` and raising it again starts the restart delay on the edge where enable is first sampled high again. `restart_req` pulses RESTART_MS x CLK_PER_MS cycles after that edge.
- R6: With `latch_mode`=0 the restart delay starts on the fault edge. `restart_req` is high for exactly one cycle, RESTART_MS x CLK_PER_MS cycles later. `restart_at_power` carries the value of `det_off` sampled on that edge: 1 means go directly to power-up, 0 means restart at discovery.
- R7: After a thermal fault, the restart delay starts on the edge after `ot_clear` is sampled, so the block never requests a restart while the port is still hot.
- R8: `fault_n` returns to 1 only on the edge where `pwr_start` is sampled while the block is waiting for power. The same edge drives `sw_off` to 0.
- R9: If `enable` is sampled low on the same edge that a fault would be raised, the fault is discarded. `sw_off` goes to 1, `fault_n` keeps its value, all timers clear, and a later re-enable powers up with no restart delay.
- R10: Under synchronous reset the outputs are `sw_off`=1, `fault_n`=1, `restart_req`=0 and `restart_at_power`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Port enable; low forces off and clears timers |
| latch_mode | input | 1 | 1 = latch off after fault, 0 = auto-retry |
| det_off | input | 1 | Discovery disabled; restart goes straight to power-up |
| pwr_start | input | 1 | One-cycle pulse from the sequencer: enter powered phase |
| ilim_active | input | 1 | Current regulator is holding the load at its limit |
| ot_trip | input | 1 | Die temperature passed the upper trip point |
| ot_clear | input | 1 | Die temperature fell below the lower release point |
| sw_off | output | 1 | Registered switch-off command |
| fault_n | output | 1 | Registered active-low fault flag |
| restart_req | output | 1 | One-cycle restart request to the sequencer |
| restart_at_power | output | 1 | Qualifies `restart_req`: 1 = power-up, 0 = discovery |

## Verification
An overcurrent timeout and an enable drop can land on the same clock edge. The bench arranges this by holding current limit for one cycle less than the timeout and then lowering enable exactly as the last limit cycle is sampled. It judges the result by checking that the fault flag stays high, and that the following power-up is not held back by any restart delay. The bench also lines up a thermal release against the restart timer, expecting the request exactly one full delay after the cooldown edge, and it checks that a pulse of `ot_trip` alone never ends the hot state.

// File: rtl/ocf_pkg.sv
package ocf_pkg;
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_READY   = 3'd1,
    ST_POWERED = 3'd2,
    ST_LATCHED = 3'd3,
    ST_COOL    = 3'd4,
    ST_RETRY   = 3'd5
  } sup_state_e;
endpackage

// File: rtl/ms_pacer.sv
// Emits one tick every CLK_PER_MS cycles while run is high; restarts from zero
// whenever run drops.
module ms_pacer #(
  parameter int CLK_PER_MS = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  generate
    if (CLK_PER_MS <= 1) begin : g_pass
      assign tick = run;
    end else begin : g_div
      localparam int CW = $clog2(CLK_PER_MS);
      localparam logic [CW-1:0] LAST = CW'(CLK_PER_MS - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end

      assign tick = run && (cnt == LAST);

      // R1: the prescaler never leaves its range
      a_r1_pace_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
      // R2: a stop clears the prescaler
      a_r2_pace_clear: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt == '0);
    end
  endgenerate
endmodule

// File: rtl/ms_window.sv
// Counts ticks while run is high; trip is high on the LIMIT_MS-th tick.
module ms_window #(
  parameter int LIMIT_MS = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic trip
);
  localparam int CW = (LIMIT_MS > 1) ? $clog2(LIMIT_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT_MS - 1);
  logic [CW-1:0] ms_cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) ms_cnt <= '0;
    else if (tick) ms_cnt <= (ms_cnt == LAST) ? '0 : ms_cnt + 1'b1;
  end

  assign trip = run && tick && (ms_cnt == LAST);

  // R1: elapsed count stays below its limit
  a_r1_window_bound: assert property (@(posedge clk) disable iff (rst)
    ms_cnt <= LAST);
  // R2: leaving the counted condition returns the count to zero
  a_r2_window_clear: assert property (@(posedge clk) disable iff (rst)
    !run |=> ms_cnt == '0);
endmodule

// File: rtl/heat_latch.sv
// Hysteresis memory: set by the upper trip, released only by the lower point.
module heat_latch (
  input  logic clk,
  input  logic rst,
  input  logic trip,
  input  logic release_pt,
  output logic hot
);
  always_ff @(posedge clk) begin
    if (rst) hot <= 1'b0;
    else if (trip) hot <= 1'b1;
    else if (release_pt) hot <= 1'b0;
  end

  // R4: without the release flag the hot state cannot end
  a_r4_hot_holds: assert property (@(posedge clk) disable iff (rst)
    (hot && !release_pt) |=> hot);
endmodule

// File: rtl/ocf_supervisor.sv
module ocf_supervisor #(
  parameter int CLK_PER_MS  = 50000,
  parameter int OC_LIMIT_MS = 60,
  parameter int RESTART_MS  = 1920
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic latch_mode,
  input  logic det_off,
  input  logic pwr_start,
  input  logic ilim_active,
  input  logic ot_trip,
  input  logic ot_clear,
  output logic sw_off,
  output logic fault_n,
  output logic restart_req,
  output logic restart_at_power
);
  import ocf_pkg::*;

  sup_state_e st, st_nx;
  logic pend;
  logic overheat;
  logic oc_run, oc_tick, oc_trip;
  logic rs_run, rs_tick, rs_trip;
  logic fault_evt, restart_evt, power_evt;

  assign oc_run = (st == ST_POWERED) && ilim_active;
  assign rs_run = (st == ST_RETRY);

  ms_pacer  #(.CLK_PER_MS(CLK_PER_MS)) u_oc_pace (
    .clk(clk), .rst(rst), .run(oc_run), .tick(oc_tick));
  ms_window #(.LIMIT_MS(OC_LIMIT_MS))  u_oc_win  (
    .clk(clk), .rst(rst), .run(oc_run), .tick(oc_tick), .trip(oc_trip));
  ms_pacer  #(.CLK_PER_MS(CLK_PER_MS)) u_rs_pace (
    .clk(clk), .rst(rst), .run(rs_run), .tick(rs_tick));
  ms_window #(.LIMIT_MS(RESTART_MS))   u_rs_win  (
    .clk(clk), .rst(rst), .run(rs_run), .tick(rs_tick), .trip(rs_trip));
  heat_latch u_heat (
    .clk(clk), .rst(rst), .trip(ot_trip), .release_pt(ot_clear), .hot(overheat));

  always_comb begin
    st_nx = st;
    if (!enable) begin
      st_nx = ST_OFF;
    end else begin
      unique case (st)
        ST_OFF:     st_nx = pend ? (overheat ? ST_COOL : ST_RETRY) : ST_READY;
        ST_READY:   if (pwr_start) st_nx = ST_POWERED;
        ST_POWERED: if (oc_trip || overheat)
                      st_nx = latch_mode ? ST_LATCHED :
                              (overheat ? ST_COOL : ST_RETRY);
        ST_LATCHED: st_nx = ST_LATCHED;
        ST_COOL:    if (!overheat) st_nx = ST_RETRY;
        ST_RETRY:   if (overheat) st_nx = ST_COOL;
                    else if (rs_trip) st_nx = ST_READY;
        default:    st_nx = ST_OFF;
      endcase
    end
  end

  assign fault_evt   = enable && (st == ST_POWERED) && (st_nx != ST_POWERED);
  assign restart_evt = enable && (st == ST_RETRY) && (st_nx == ST_READY);
  assign power_evt   = enable && (st == ST_READY) && (st_nx == ST_POWERED);

  always_ff @(posedge clk) begin
    if (rst) begin
      st               <= ST_OFF;
      pend             <= 1'b0;
      sw_off           <= 1'b1;
      fault_n          <= 1'b1;
      restart_req      <= 1'b0;
      restart_at_power <= 1'b0;
    end else begin
      st          <= st_nx;
      sw_off      <= (st_nx != ST_POWERED);
      restart_req <= restart_evt;
      if (restart_evt) restart_at_power <= det_off;
      if (fault_evt) pend <= 1'b1;
      else if (restart_evt) pend <= 1'b0;
      if (power_evt) fault_n <= 1'b1;
      else if (fault_evt) fault_n <= 1'b0;
    end
  end

  // R3: a falling fault flag always comes with the switch off
  a_r3_off_with_fault: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_n) |-> sw_off);
  // R6: restart request lasts a single cycle
  a_r6_req_single: assert property (@(posedge clk) disable iff (rst)
    restart_req |=> !restart_req);
  // R7: while still hot, recovery stays parked in cooldown
  a_r7_hold_cool: assert property (@(posedge clk) disable iff (rst)
    (st == ST_COOL && overheat && enable) |=> st == ST_COOL);
  // R8: fault flag is released only by a power-mode start
  a_r8_release_on_start: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_n) |-> $past(pwr_start));
  // R9: enable low forces off and suppresses any restart
  a_r9_enable_wins: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (sw_off && !restart_req));
endmodule

// File: tb/tb_ocf_supervisor.sv
module tb_ocf_supervisor;
  localparam int CPM = 4;
  localparam int OCM = 5;
  localparam int RSM = 6;
  localparam int N   = OCM * CPM;
  localparam int W   = RSM * CPM;

  logic clk = 1'b0;
  logic rst, enable, latch_mode, det_off, pwr_start, ilim_active, ot_trip, ot_clear;
  logic sw_off, fault_n, restart_req, restart_at_power;

  typedef struct {
    logic  sw;
    logic  fl;
    logic  rq;
    logic  chk_dir;
    logic  dir;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ocf_supervisor #(.CLK_PER_MS(CPM), .OC_LIMIT_MS(OCM), .RESTART_MS(RSM)) dut (
    .clk(clk), .rst(rst), .enable(enable), .latch_mode(latch_mode),
    .det_off(det_off), .pwr_start(pwr_start), .ilim_active(ilim_active),
    .ot_trip(ot_trip), .ot_clear(ot_clear), .sw_off(sw_off), .fault_n(fault_n),
    .restart_req(restart_req), .restart_at_power(restart_at_power));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input logic sw, input logic fl, input logic rq, input string tag);
    exp_t e;
    e.sw = sw; e.fl = fl; e.rq = rq; e.chk_dir = 1'b0; e.dir = 1'b0; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic expect_dir(input logic d, input string tag);
    exp_t e;
    e.sw = 1'b0; e.fl = 1'b0; e.rq = 1'b0; e.chk_dir = 1'b1; e.dir = d; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic power_on();
    pwr_start = 1'b1; step(1); pwr_start = 1'b0;
  endtask

  // monitor: compare pending expectations shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk); #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_vec++;
        if (e.chk_dir) begin
          if (restart_at_power !== e.dir) begin
            n_bad++;
            $display("FAIL %s: restart_at_power=%b expected %b", e.tag, restart_at_power, e.dir);
          end
        end else if ({sw_off, fault_n, restart_req} !== {e.sw, e.fl, e.rq}) begin
          n_bad++;
          $display("FAIL %s: sw_off/fault_n/restart_req=%b%b%b expected %b%b%b",
                   e.tag, sw_off, fault_n, restart_req, e.sw, e.fl, e.rq);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R10: watchdog expired, actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; enable = 1'b0; latch_mode = 1'b0; det_off = 1'b0; pwr_start = 1'b0;
    ilim_active = 1'b0; ot_trip = 1'b0; ot_clear = 1'b0;
    step(3);
    expect_out(1, 1, 0, "R10 reset state");
    expect_dir(0, "R10 reset qualifier");
    rst = 1'b0; step(1);

    enable = 1'b1; step(1);
    expect_out(1, 1, 0, "R10 ready after enable");
    power_on();
    expect_out(0, 1, 0, "R8 first power on");

    // R1 / R2: interrupted overloads never fault
    ilim_active = 1'b1; step(N - 1);
    expect_out(0, 1, 0, "R1 one cycle short of timeout");
    ilim_active = 1'b0; step(1);
    ilim_active = 1'b1; step(N - 1);
    expect_out(0, 1, 0, "R2 count cleared by drop");
    step(1);
    expect_out(1, 0, 0, "R1 timeout fault");
    ilim_active = 1'b0;

    // R6 auto-retry after overcurrent
    step(W - 1);
    expect_out(1, 0, 0, "R3 fault held during delay");
    step(1);
    expect_out(1, 0, 1, "R6 restart request");
    expect_dir(0, "R6 restart at discovery");
    step(1);
    expect_out(1, 0, 0, "R6 single-cycle request");
    power_on();
    expect_out(0, 1, 0, "R8 release at power start");

    // R4 / R7 thermal fault with hysteresis
    ot_trip = 1'b1; step(1); ot_trip = 1'b0;
    expect_out(0, 1, 0, "R4 hot recorded, not yet off");
    step(1);
    expect_out(1, 0, 0, "R4 thermal fault");
    step(W + 10);
    expect_out(1, 0, 0, "R4 R7 still hot, no restart");
    ot_clear = 1'b1; step(1); ot_clear = 1'b0;
    step(W);
    expect_out(1, 0, 0, "R7 delay counted from cooldown");
    step(1);
    expect_out(1, 0, 1, "R7 restart after cooldown");
    step(1);
    power_on();
    expect_out(0, 1, 0, "R8 power after thermal");

    // R5 latch-off
    latch_mode = 1'b1;
    ilim_active = 1'b1; step(N); ilim_active = 1'b0;
    expect_out(1, 0, 0, "R5 latched fault");
    step(W + 10);
    expect_out(1, 0, 0, "R5 stays off without toggle");
    enable = 1'b0; step(1);
    expect_out(1, 0, 0, "R5 enable low keeps flag");
    enable = 1'b1; step(1);
    step(W - 1);
    expect_out(1, 0, 0, "R5 delay after toggle");
    step(1);
    expect_out(1, 0, 1, "R5 restart after toggle");
    step(1);
    latch_mode = 1'b0;
    power_on();
    expect_out(0, 1, 0, "R8 power after latch");

    // R9 enable low on the timeout edge
    ilim_active = 1'b1; step(N - 1);
    enable = 1'b0; step(1);
    expect_out(1, 1, 0, "R9 enable low discards fault");
    ilim_active = 1'b0; enable = 1'b1; step(1);
    expect_out(1, 1, 0, "R9 ready without delay");
    power_on();
    expect_out(0, 1, 0, "R9 immediate power up");

    // R6 restart qualifier with discovery disabled
    det_off = 1'b1;
    ilim_active = 1'b1; step(N); ilim_active = 1'b0;
    expect_out(1, 0, 0, "R1 second timeout");
    step(W);
    expect_out(1, 0, 1, "R6 direct restart request");
    expect_dir(1, "R6 restart at power-up");
    step(2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule